// File: doc/BRIEF.md
# Register Datapath with Word-Wide Parallel Scan

This block is a small register-transfer datapath with four word registers. The registers are an operand register, a copy register, an offset register and a page register. In normal operation the registers load under external select and load controls. The operand register takes either the input word or the copy register. The copy register takes the operand. The offset register takes either the copy register or the sum of operand and copy. The page register takes the operand plus one.

A single test-mode pin turns the same wiring into word-wide parallel scan chains. The registers are joined by multiplexer paths and direct connections that already exist. Every bit lane becomes its own one-bit chain. The chains run from the data input to the core outputs: operand, copy, offset and then the low address output, with a branch from the operand register through the page register to the high address output. In test mode the block overrides the functional selects and load enables. A dedicated test multiplexer feeds the page register, because its own functional source, an incrementer, cannot carry data through unchanged.

While test mode is high, a shift enable advances every chain by one word per clock and holds all chains while low. A freeze control holds only the page register, so that data on the short branch can wait for data on the long branch. Used as a transparency path, a word applied at the data input reaches the high address output after two clocks and the low address output after three.

Top module: `rdp_scan_core`

## Requirements
- R1: While reset is high at a clock edge, all four registers clear to zero, so `data_out`, `addr_lo` and `addr_hi` read 0.
- R2: With `test_mode` low and `ld[0]` high, the operand register loads `din` when `sel_a` is 0 and the copy register when `sel_a` is 1. With `ld[0]` low it holds.
- R3: With `test_mode` low, each register loads only when its own load bit is high, and `scan_en` and `freeze` have no effect. The load bits are `ld[1]` for copy, `ld[2]` for offset and `ld[3]` for page. The copy register takes the operand. The offset register takes the copy register when `sel_c` is 0, and operand plus copy modulo 2^W when `sel_c` is 1. The page register takes operand plus one modulo 2^W.
- R4: With `test_mode` and `scan_en` high and `freeze` low, each clock edge shifts the chains, whatever `sel_a`, `sel_c` and `ld` are. The operand register takes `din`, copy and page both take the operand, and offset takes copy.
- R5: With `test_mode` high and `scan_en` low, all registers hold for any values of the other inputs.
- R6: With `test_mode` and `freeze` high, the page register holds. The other registers still shift when `scan_en` is high.
- R7: In test mode with shifting enabled, a word applied at `din` appears at `addr_hi` and `data_out` after two clock edges and at `addr_lo` after three. It does not appear at those outputs earlier.
- R8: The chains fill with three shift vectors, the depth of the longest chain. One further vector, applied with `test_mode` low, captures a functional result that is visible at the outputs at once. The case checked is the offset sum of the last two vectors shifted in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | The one added test pin; high selects scan/transparency behaviour |
| scan_en | input | 1 | In test mode, high shifts the chains, low holds them |
| freeze | input | 1 | In test mode, holds the page register |
| din | input | W | Data input word, head of every chain |
| sel_a | input | 1 | Operand source: 0 = din, 1 = copy register |
| sel_c | input | 1 | Offset source: 0 = copy register, 1 = operand + copy |
| ld | input | 4 | Functional load enables: bit0 operand, bit1 copy, bit2 offset, bit3 page |
| data_out | output | W | Copy register contents |
| addr_lo | output | W | Offset register contents (low address) |
| addr_hi | output | W | Page register contents (high address) |

## Verification
Every register is one edge from its source, so a control or data change applied before an edge shows at the outputs just after that edge. A word entered at `din` needs two edges to reach `data_out` and `addr_hi`, and three to reach `addr_lo`. The bench changes inputs on the falling edge and compares all three outputs on the following falling edge. The expected values come from a per-edge model of the requirements. The latency and fill-and-capture checks count edges explicitly and also test that a marker word has not yet arrived one edge early.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    localparam int unsigned NREG        = 4;
    localparam int unsigned IDX_A       = 0;
    localparam int unsigned IDX_B       = 1;
    localparam int unsigned IDX_C       = 2;
    localparam int unsigned IDX_P       = 3;
    // longest chain: operand -> copy -> offset
    localparam int unsigned CHAIN_DEPTH = 3;
    localparam int unsigned FILL_VECTORS = CHAIN_DEPTH + 1;

    typedef struct packed {
        logic            sel_a;
        logic            sel_c;
        logic [NREG-1:0] ld;
    } ctrl_t;

    typedef enum logic [1:0] {
        MODE_FUNC  = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_SHIFT = 2'd2
    } mode_e;

    function automatic mode_e pick_mode(input logic tm, input logic se);
        if (!tm)     return MODE_FUNC;
        else if (se) return MODE_SHIFT;
        else         return MODE_HOLD;
    endfunction

endpackage

// File: rtl/rdp_word_reg.sv
module rdp_word_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (ld) q <= d;
    end

    // R3/R5: a register whose load is low keeps its word
    assert_unloaded_holds_R5: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(q));

endmodule

// File: rtl/rdp_test_ctrl.sv
module rdp_test_ctrl
    import rdp_pkg::*;
(
    input  logic  test_mode,
    input  logic  scan_en,
    input  logic  freeze,
    input  ctrl_t func_ctl,
    output ctrl_t eff_ctl,
    output logic  p_test_pick
);

    mode_e mode;

    always_comb begin
        mode        = pick_mode(test_mode, scan_en);
        eff_ctl     = func_ctl;
        p_test_pick = 1'b0;
        if (mode != MODE_FUNC) begin
            // existing operand mux: force its select-0 (din) leg
            eff_ctl.sel_a = 1'b0;
            // existing offset mux: force its select-0 (copy) leg
            eff_ctl.sel_c = 1'b0;
            eff_ctl.ld    = '0;
            if (mode == MODE_SHIFT) begin
                eff_ctl.ld[IDX_A] = 1'b1;
                eff_ctl.ld[IDX_B] = 1'b1;
                eff_ctl.ld[IDX_C] = 1'b1;
                eff_ctl.ld[IDX_P] = 1'b1;
            end
            if (freeze) eff_ctl.ld[IDX_P] = 1'b0;
            p_test_pick = 1'b1;
        end
    end

endmodule

// File: rtl/rdp_src_mux.sv
module rdp_src_mux #(
    parameter int unsigned W = 16
) (
    input  logic         sel_a,
    input  logic         sel_c,
    input  logic         p_test_pick,
    input  logic [W-1:0] din,
    input  logic [W-1:0] q_a,
    input  logic [W-1:0] q_b,
    output logic [W-1:0] d_a,
    output logic [W-1:0] d_b,
    output logic [W-1:0] d_c,
    output logic [W-1:0] d_p
);

    logic [W-1:0] sum_ab;
    logic [W-1:0] inc_a;

    always_comb begin
        sum_ab = q_a + q_b;
        inc_a  = q_a + W'(1);
        d_a    = sel_a ? q_b : din;
        d_b    = q_a;                    // direct wire, no mux
        d_c    = sel_c ? sum_ab : q_b;
        d_p    = p_test_pick ? q_a : inc_a; // added test mux
    end

endmodule

// File: rtl/rdp_scan_core.sv
module rdp_scan_core
    import rdp_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            test_mode,
    input  logic            scan_en,
    input  logic            freeze,
    input  logic [W-1:0]    din,
    input  logic            sel_a,
    input  logic            sel_c,
    input  logic [NREG-1:0] ld,
    output logic [W-1:0]    data_out,
    output logic [W-1:0]    addr_lo,
    output logic [W-1:0]    addr_hi
);

    ctrl_t        func_ctl;
    ctrl_t        eff_ctl;
    logic         p_test_pick;
    logic [W-1:0] d_word [NREG];
    logic [W-1:0] q_word [NREG];

    assign func_ctl.sel_a = sel_a;
    assign func_ctl.sel_c = sel_c;
    assign func_ctl.ld    = ld;

    rdp_test_ctrl u_ctrl (
        .test_mode   (test_mode),
        .scan_en     (scan_en),
        .freeze      (freeze),
        .func_ctl    (func_ctl),
        .eff_ctl     (eff_ctl),
        .p_test_pick (p_test_pick)
    );

    rdp_src_mux #(.W(W)) u_mux (
        .sel_a       (eff_ctl.sel_a),
        .sel_c       (eff_ctl.sel_c),
        .p_test_pick (p_test_pick),
        .din         (din),
        .q_a         (q_word[IDX_A]),
        .q_b         (q_word[IDX_B]),
        .d_a         (d_word[IDX_A]),
        .d_b         (d_word[IDX_B]),
        .d_c         (d_word[IDX_C]),
        .d_p         (d_word[IDX_P])
    );

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        rdp_word_reg #(.W(W)) u_reg (
            .clk (clk),
            .rst (rst),
            .ld  (eff_ctl.ld[g]),
            .d   (d_word[g]),
            .q   (q_word[g])
        );
    end

    assign data_out = q_word[IDX_B];
    assign addr_lo  = q_word[IDX_C];
    assign addr_hi  = q_word[IDX_P];

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (addr_lo == '0 && addr_hi == '0 && data_out == '0));

    assert_page_incr_R3: assert property (@(posedge clk) disable iff (rst)
        (!test_mode && ld[IDX_P]) |=> (addr_hi == $past(q_word[IDX_A]) + W'(1)));

    assert_shift_chain_R4: assert property (@(posedge clk) disable iff (rst)
        (test_mode && scan_en && !freeze) |=>
            (addr_hi == $past(q_word[IDX_A]) && addr_lo == $past(data_out)));

    assert_hold_all_R5: assert property (@(posedge clk) disable iff (rst)
        (test_mode && !scan_en) |=>
            ($stable(addr_lo) && $stable(addr_hi) && $stable(data_out)));

    assert_freeze_page_R6: assert property (@(posedge clk) disable iff (rst)
        (test_mode && freeze) |=> $stable(addr_hi));

endmodule

// File: tb/rdp_scan_core_bench.sv
module rdp_scan_core_bench;
    import rdp_pkg::*;

    localparam int unsigned W = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            test_mode = 1'b0;
    logic            scan_en = 1'b0;
    logic            freeze = 1'b0;
    logic [W-1:0]    din = '0;
    logic            sel_a = 1'b0;
    logic            sel_c = 1'b0;
    logic [NREG-1:0] ld = '0;
    logic [W-1:0]    data_out, addr_lo, addr_hi;

    logic [W-1:0] ea, eb, ec, ep;
    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    rdp_scan_core #(.W(W)) u_rdp_scan_core (
        .clk(clk), .rst(rst), .test_mode(test_mode), .scan_en(scan_en),
        .freeze(freeze), .din(din), .sel_a(sel_a), .sel_c(sel_c), .ld(ld),
        .data_out(data_out), .addr_lo(addr_lo), .addr_hi(addr_hi)
    );

    task automatic check(input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " data_out"}, data_out, eb);
        check({tag, " addr_lo"},  addr_lo,  ec);
        check({tag, " addr_hi"},  addr_hi,  ep);
    endtask

    // one edge: drive at negedge, model the edge, compare at next negedge
    task automatic step(input logic tm, input logic se, input logic fz,
                        input logic sa, input logic sc, input logic [NREG-1:0] l,
                        input logic [W-1:0] d, input string tag);
        logic [W-1:0] na, nb, nc, np;
        test_mode = tm; scan_en = se; freeze = fz;
        sel_a = sa; sel_c = sc; ld = l; din = d;
        na = ea; nb = eb; nc = ec; np = ep;
        if (tm) begin
            if (se) begin
                na = d; nb = ea; nc = eb;
            end
            if (se && !fz) np = ea;
        end else begin
            if (l[0]) na = sa ? eb : d;
            if (l[1]) nb = ea;
            if (l[2]) nc = sc ? ea + eb : eb;
            if (l[3]) np = ea + 16'd1;
        end
        @(posedge clk);
        ea = na; eb = nb; ec = nc; ep = np;
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_fail++;
                n_checks++;
                $display("FAIL watchdog: got %0d cycles expected under 100000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin : stimulus
        logic [W-1:0] v0, v1, v2, mark;
        ea = '0; eb = '0; ec = '0; ep = '0;
        // R1: reset clears everything, even with loads requested
        ld = 4'hF; din = 16'hBEEF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1 reset");
        rst = 1'b0;

        // R2 / R3: functional sweep, scan_en and freeze toggled but ignored
        for (int i = 0; i < 400; i++) begin
            step(1'b0, i[2], i[3], i[0], i[1], 4'((i * 7 + 3) >> 1),
                 16'(i * 16'h9E37 + 16'h1234), "R2/R3 functional");
        end

        // R4: shifting with arbitrary functional controls
        for (int i = 0; i < 200; i++) begin
            step(1'b1, 1'b1, 1'b0, i[0], i[1], 4'(i),
                 16'(i * 16'h3B5D ^ 16'hA5A5), "R4 shift");
        end

        // R5: hold while shift disabled
        for (int i = 0; i < 40; i++) begin
            step(1'b1, 1'b0, i[1], i[0], i[2], 4'hF,
                 16'(i * 16'h1111), "R5 hold");
        end

        // R6: freeze keeps page while the rest shift
        for (int i = 0; i < 30; i++) begin
            step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'(i),
                 16'(i * 16'h0F1E + 16'h7), "R6 freeze");
        end

        // R7: transparency latency of a marker word
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 16'h0000, "R7 flush");
        mark = 16'hC3A9;
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, mark, "R7 edge1");
        check("R7 addr_hi not yet at edge1", addr_hi, 16'h0000);
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 16'h0000, "R7 edge2");
        check("R7 addr_hi at edge2", addr_hi, mark);
        check("R7 data_out at edge2", data_out, mark);
        check("R7 addr_lo not yet at edge2", addr_lo, 16'h0000);
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 16'h0000, "R7 edge3");
        check("R7 addr_lo at edge3", addr_lo, mark);

        // R8: fill with CHAIN_DEPTH vectors, capture with one more
        for (int k = 0; k < 3; k++) begin
            v0 = 16'h1357 + 16'(k * 16'h2222);
            v1 = 16'hF00D - 16'(k * 16'h0101);
            v2 = 16'h4242 ^ 16'(k * 16'h0F0F);
            step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, v0, "R8 fill0");
            step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, v1, "R8 fill1");
            step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, v2, "R8 fill2");
            check("R8 filled addr_lo", addr_lo, v0);
            check("R8 filled data_out", data_out, v1);
            check("R8 filled addr_hi", addr_hi, v1);
            step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0100, 16'h0000, "R8 capture");
            check("R8 captured addr_lo", addr_lo, 16'(v1 + v2));
            check("R8 capture vectors", 16'(FILL_VECTORS), 16'd4);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule